// File: doc/BRIEF.md
# Bus-Mapped Parallel I/O Port

This block is a peripheral that sits on an 8-bit processor bus. It gives the processor two 8-bit ports, A and B. Each pin of each port can be set as an input or as an output on its own. The processor reaches the block through a window of 16 register slots, picked by four select lines. Two chip selects, one active-high and one active-low, gate every access, so a simple address decoder can place the window in the memory map by wiring address bits straight to the selects.

A write is taken on the rising edge of the bus clock when the block is selected and read/write is low. A read is combinational and returns its value while the block is selected and read/write is high. When the block is not selected, it releases the data bus. The bus is modelled as a separate output value and output enable, and the chip top level joins them into a tri-state pad.

Each port drives its pins with an output value and a per-bit output enable. A pin set as an input can be read back through the port's output slot. Slots 4 to 15 are not used.

Top module: `bus_pio`

## Requirements
- R1: While `rst_n` is low, every direction bit and output latch is 0, so `pa_out`, `pa_oe`, `pb_out` and `pb_oe` all read 0x00. Reset is asynchronous and can be applied at any time.
- R2: The block is selected only when `cs_hi` is 1 and `cs_lo_n` is 0. `data_oe` is 1 exactly when the block is selected and `rw_n` is 1.
- R3: A selected write (`rw_n` = 0) to slot 3 loads the port A direction register. From the next rising edge, `pa_oe` equals the written byte, and a 1 bit marks an output pin.
- R4: A selected write to slot 1 loads the port A output latch. From the next rising edge, `pa_out` equals the written byte.
- R5: Port B mirrors port A. Slot 0 is the port B output latch, driven on `pb_out`. Slot 2 is the port B direction register, driven on `pb_oe`.
- R6: A selected read of slot 1 (or slot 0) returns, bit by bit, the output latch where the direction bit is 1 and the level on `pa_in` (or `pb_in`) where it is 0.
- R7: A selected read of slot 3 (or slot 2) returns the port A (or port B) direction register.
- R8: A selected read of any slot from 4 to 15 returns 0x00 with `data_oe` = 1. A selected write to these slots changes no port output or enable.
- R9: A write cycle while the block is not selected changes no register, and a selected read cycle changes no register.
- R10: While the block is not selected, `data_oe` is 0 and `data_out` is 0x00, whatever the state of `rw_n` and `rs`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; writes are taken on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| rw_n | input | 1 | 1 = read, 0 = write |
| rs | input | 4 | Register slot select |
| data_in | input | 8 | Write data from the processor |
| data_out | output | 8 | Read data to the processor |
| data_oe | output | 1 | Enable for the data bus drivers |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-pin output enable |

## Verification
The four registers feed the port pins directly, so a bad latch or direction bit shows up on `pa_out`, `pa_oe`, `pb_out` or `pb_oe` one edge after the write that caused it. A bad bit stays visible until it is rewritten or reset. The bench also reads every register back over the bus, where a wrong value in the readback mix appears in the same cycle as the read. Writes that should be ignored (deselected, the unused slots, read cycles) are checked at the pins in the cycle after the stimulus. The bench also forces a reset in the middle of the run, so a fault in the clear path is caught on the next sample.

// File: rtl/bus_pio.sv
module bus_pio #(
  parameter int W     = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             rw_n,
  input  logic [SEL_W-1:0] rs,
  input  logic [W-1:0]     data_in,
  output logic [W-1:0]     data_out,
  output logic             data_oe,
  input  logic [W-1:0]     pa_in,
  output logic [W-1:0]     pa_out,
  output logic [W-1:0]     pa_oe,
  input  logic [W-1:0]     pb_in,
  output logic [W-1:0]     pb_out,
  output logic [W-1:0]     pb_oe
);
  localparam logic [SEL_W-1:0] SLOT_OUT_B = SEL_W'(0);
  localparam logic [SEL_W-1:0] SLOT_OUT_A = SEL_W'(1);
  localparam logic [SEL_W-1:0] SLOT_DIR_B = SEL_W'(2);
  localparam logic [SEL_W-1:0] SLOT_DIR_A = SEL_W'(3);

  logic [W-1:0] lat_a, lat_b, dir_a, dir_b;
  logic [W-1:0] rd_val;
  logic         sel, wr;

  assign sel = cs_hi & ~cs_lo_n;
  assign wr  = sel & ~rw_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a <= '0;
      lat_b <= '0;
      dir_a <= '0;
      dir_b <= '0;
    end else if (wr) begin
      case (rs)
        SLOT_OUT_B: lat_b <= data_in;
        SLOT_OUT_A: lat_a <= data_in;
        SLOT_DIR_B: dir_b <= data_in;
        SLOT_DIR_A: dir_a <= data_in;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rs)
      SLOT_OUT_B: rd_val = (lat_b & dir_b) | (pb_in & ~dir_b);
      SLOT_OUT_A: rd_val = (lat_a & dir_a) | (pa_in & ~dir_a);
      SLOT_DIR_B: rd_val = dir_b;
      SLOT_DIR_A: rd_val = dir_a;
      default:    rd_val = '0;
    endcase
  end

  assign data_oe  = sel & rw_n;
  assign data_out = data_oe ? rd_val : '0;

  assign pa_out = lat_a;
  assign pa_oe  = dir_a;
  assign pb_out = lat_b;
  assign pb_oe  = dir_b;
endmodule

// File: rtl/bus_pio_chk.sv
module bus_pio_chk #(
  parameter int W     = 8,
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_hi,
  input logic             cs_lo_n,
  input logic             rw_n,
  input logic [SEL_W-1:0] rs,
  input logic [W-1:0]     data_in,
  input logic [W-1:0]     data_out,
  input logic             data_oe,
  input logic [W-1:0]     pa_out,
  input logic [W-1:0]     pa_oe,
  input logic [W-1:0]     pb_out,
  input logic [W-1:0]     pb_oe
);
  // R1
  always @(posedge clk)
    if (!rst_n)
      reset_clear_chk: assert (pa_out == '0 && pa_oe == '0 && pb_out == '0 && pb_oe == '0);

  // R10
  deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_hi && !cs_lo_n) |-> (!data_oe && data_out == '0));

  // R2
  select_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && !cs_lo_n && rw_n) |-> data_oe);

  // R3
  dir_a_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && !cs_lo_n && !rw_n && rs == SEL_W'(3)) |=> pa_oe == $past(data_in));

  // R4
  out_a_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && !cs_lo_n && !rw_n && rs == SEL_W'(1)) |=> pa_out == $past(data_in));

  // R5
  out_b_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && !cs_lo_n && !rw_n && rs == SEL_W'(0)) |=> pb_out == $past(data_in));

  // R7
  dir_a_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && !cs_lo_n && rw_n && rs == SEL_W'(3)) |-> data_out == pa_oe);

  // R8
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi && !cs_lo_n && rw_n && rs > SEL_W'(3)) |-> data_out == '0);

  // R9
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs_hi && !cs_lo_n) || rw_n) |=>
      ($stable(pa_out) && $stable(pa_oe) && $stable(pb_out) && $stable(pb_oe)));
endmodule

bind bus_pio bus_pio_chk #(.W(W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .rw_n(rw_n),
  .rs(rs), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
  .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe)
);

// File: tb/tb_bus_pio.sv
`timescale 1ns/1ps
module tb_bus_pio;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_hi = 1'b0, cs_lo_n = 1'b1, rw_n = 1'b1;
  logic [3:0] rs = '0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out, pa_out, pa_oe, pb_out, pb_oe;
  logic       data_oe;
  logic [7:0] ext_a = 8'h00, ext_b = 8'h00;

  bus_pio dut (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .rw_n(rw_n),
    .rs(rs), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .pa_in(ext_a), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(ext_b), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit         is_bus;
    logic       oe;
    logic [7:0] d, pao, paoe, pbo, pboe;
    string      tag;
  } item_t;

  item_t      sb[$];
  item_t      it;
  int         vectors = 0, errs = 0;
  bit         done = 1'b0;
  logic [7:0] m_ora = 0, m_orb = 0, m_ddra = 0, m_ddrb = 0;

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      it = sb.pop_front();
      vectors++;
      if (it.is_bus) begin
        if (data_oe !== it.oe || data_out !== it.d) begin
          errs++;
          $display("FAIL %s bus: oe=%b data=%h expected oe=%b data=%h",
                   it.tag, data_oe, data_out, it.oe, it.d);
        end
      end else if (pa_out !== it.pao || pa_oe !== it.paoe ||
                   pb_out !== it.pbo || pb_oe !== it.pboe) begin
        errs++;
        $display("FAIL %s ports: a=%h/%h b=%h/%h expected a=%h/%h b=%h/%h",
                 it.tag, pa_out, pa_oe, pb_out, pb_oe, it.pao, it.paoe, it.pbo, it.pboe);
      end
    end
  end

  function automatic logic [7:0] mdl_read(logic [3:0] a);
    case (a)
      4'd0: return (m_orb & m_ddrb) | (ext_b & ~m_ddrb);
      4'd1: return (m_ora & m_ddra) | (ext_a & ~m_ddra);
      4'd2: return m_ddrb;
      4'd3: return m_ddra;
      default: return 8'h00;
    endcase
  endfunction

  task automatic drive(bit ch, bit cl, bit rw, logic [3:0] a, logic [7:0] d);
    @(posedge clk); #1;
    cs_hi = ch; cs_lo_n = cl; rw_n = rw; rs = a; data_in = d;
  endtask

  task automatic push_ports(string tag);
    item_t x;
    x.is_bus = 0; x.oe = 0; x.d = 0;
    x.pao = m_ora; x.paoe = m_ddra; x.pbo = m_orb; x.pboe = m_ddrb; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic wr(bit ch, bit cl, logic [3:0] a, logic [7:0] d, string tag);
    drive(ch, cl, 1'b0, a, d);
    if (ch && !cl)
      case (a)
        4'd0: m_orb = d;
        4'd1: m_ora = d;
        4'd2: m_ddrb = d;
        4'd3: m_ddra = d;
        default: ;
      endcase
    drive(1'b0, 1'b1, 1'b1, 4'd0, 8'h00);
    push_ports(tag);
  endtask

  task automatic rd(bit ch, bit cl, bit rw, logic [3:0] a, string tag);
    item_t x;
    drive(ch, cl, rw, a, 8'hC3);
    x.is_bus = 1;
    x.oe = ch && !cl && rw;
    x.d = x.oe ? mdl_read(a) : 8'h00;
    x.pao = 0; x.paoe = 0; x.pbo = 0; x.pboe = 0; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic do_reset(string tag);
    @(posedge clk); #1;
    rst_n = 1'b0;
    m_ora = 0; m_orb = 0; m_ddra = 0; m_ddrb = 0;
    push_ports(tag);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    ext_b = 8'h5A;
    push_ports("R1 reset state");
    @(posedge clk); #1 rst_n = 1'b1;
    rd(1, 0, 1, 4'd0, "R1 port B readback after reset");
    rd(1, 0, 1, 4'd2, "R1 port B direction after reset");

    // R3, R4: pattern on port A
    wr(1, 0, 4'd3, 8'hFF, "R3 port A direction write");
    rd(1, 0, 1, 4'd3, "R7 port A direction read");
    wr(1, 0, 4'd1, 8'h02, "R4 port A latch 0x02");
    wr(1, 0, 4'd1, 8'h05, "R4 port A latch 0x05");
    rd(1, 0, 1, 4'd1, "R6 port A all-output readback");

    // R5, R6: port B mixed direction
    wr(1, 0, 4'd2, 8'h0F, "R5 port B direction write");
    wr(1, 0, 4'd0, 8'hA5, "R5 port B latch write");
    ext_b = 8'h3C;
    rd(1, 0, 1, 4'd0, "R6 port B mixed readback");
    rd(1, 0, 1, 4'd2, "R7 port B direction read");
    wr(1, 0, 4'd3, 8'h81, "R3 port A partial direction");
    ext_a = 8'h7E;
    rd(1, 0, 1, 4'd1, "R6 port A mixed readback");

    // R8: unused slots
    wr(1, 0, 4'd7, 8'hFF, "R8 write to slot 7 ignored");
    wr(1, 0, 4'd15, 8'h00, "R8 write to slot 15 ignored");
    rd(1, 0, 1, 4'd9, "R8 slot 9 reads zero");
    rd(1, 0, 1, 4'd4, "R8 slot 4 reads zero");

    // R9: writes without selection, read cycles
    wr(0, 0, 4'd1, 8'h77, "R9 write with cs_hi low");
    wr(1, 1, 4'd0, 8'h77, "R9 write with cs_lo_n high");
    wr(0, 1, 4'd3, 8'h00, "R9 write with both selects off");
    rd(1, 0, 1, 4'd1, "R9 read cycle leaves state");
    drive(0, 1, 1, 4'd0, 8'h00);
    push_ports("R9 state after read cycle");

    // R2, R10: selection decode and bus release
    rd(0, 0, 1, 4'd3, "R2 cs_hi low not selected");
    rd(1, 1, 1, 4'd3, "R2 cs_lo_n high not selected");
    rd(0, 1, 0, 4'd1, "R10 deselected write-phase released");
    rd(1, 0, 0, 4'd1, "R2 selected write drives no bus");
    drive(0, 1, 1, 4'd0, 8'h00);
    m_ora = 8'hC3;
    push_ports("R4 latch via selected write cycle");

    // R1: reset in mid-run
    do_reset("R1 mid-run reset clears state");
    rd(1, 0, 1, 4'd3, "R1 direction A zero after reset");
    rd(1, 0, 1, 4'd1, "R1 port A reads pins after reset");

    drive(0, 1, 1, 4'd0, 8'h00);
    @(posedge clk); @(negedge clk); #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule